// File: doc/BRIEF.md
# Line Memory Arbiter for Two Read Ports and One Write Port

This block shares one line-wide memory among three requesters: a data-side reader, an instruction-side reader and a write-back writer. The storage is built from interleaved word banks, so a whole line of `WORDS` words of `WORD_W` bits moves in a single access. Word k of a line lives in bank k, and every bank sees the same line address.

A requester raises its request with a stable line address. For the writer, it also holds the write line stable. It keeps the request high until its own one-cycle done pulse appears. When the arbiter is idle it grants exactly one requester, chosen by fixed priority: data reads first, then instruction reads, then write-backs. The arbiter then runs the access for a fixed `LAT` cycles and pulses done to that requester alone. On a read, the line is valid on the read-data outputs in the same cycle as done. After every access the arbiter spends one cycle idle before it arbitrates again.

Top module: `line_mem_arbiter`

## Requirements
- R1: After reset no done output is high, and the arbiter is idle, so the first request is accepted without delay.
- R2: When requests are pending at an idle edge, the data port wins over the instruction port, which wins over the write-back port.
- R3: A write-back stores the full 2-word line in one access, with bits [31:0] (word 0) in bank 0 and bits [63:32] (word 1) in bank 1. A later read returns both words unchanged.
- R4: If an idle arbiter accepts a request at edge G, that requester's done is high for exactly one cycle, following edge G+LAT, and no other done is high.
- R5: A granted access is never preempted. A higher-priority request that arrives during an access is served only after that access completes.
- R6: A waiting write-back receives no done while reads keep winning. It is served once no read is pending.
- R7: With no request pending the arbiter stays idle and raises no done.
- R8: The data and instruction ports read the same storage.
- R9: A write changes only the addressed line.
- R10: Back-to-back accesses are spaced LAT+1 cycles apart, because of one idle cycle after each completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_req | input | 1 | Data-side read request |
| d_addr | input | LINE_AW | Data-side line address |
| d_done | output | 1 | Data read complete, one cycle |
| d_rdata | output | WORDS*WORD_W | Read line, valid while d_done is high |
| i_req | input | 1 | Instruction-side read request |
| i_addr | input | LINE_AW | Instruction-side line address |
| i_done | output | 1 | Instruction read complete, one cycle |
| i_rdata | output | WORDS*WORD_W | Read line, valid while i_done is high |
| w_req | input | 1 | Write-back request |
| w_addr | input | LINE_AW | Write-back line address |
| w_wdata | input | WORDS*WORD_W | Write-back line data |
| w_done | output | 1 | Write complete, one cycle |

## Verification
A grant latched for the wrong requester is seen at the ports LAT+1 cycles after the request, as a done pulse on the wrong port or in the wrong order. A counter that is off by one moves every done pulse by a cycle, and the first access after reset exposes it. A bank given the wrong word slice or address shows up on the first read-back after a write, as a swapped or stale half-line. A grant that is not held shows up as an early done for a late high-priority request.

// File: rtl/lma_pkg.sv
`timescale 1ns/1ps
package lma_pkg;
   localparam int unsigned NREQ    = 3;
   localparam int unsigned P_DATA  = 0;
   localparam int unsigned P_INSTR = 1;
   localparam int unsigned P_WB    = 2;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } lma_state_e;
endpackage

// File: rtl/lma_pick.sv
`timescale 1ns/1ps
// Fixed-priority picker: the lowest index that requests wins.
module lma_pick #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] win
);
   always_comb begin
      win = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) begin
            win    = '0;
            win[k] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lma_seq.sv
`timescale 1ns/1ps
// Access sequencer: grant latch, fixed-latency counter, done pulse.
module lma_seq
   import lma_pkg::*;
#(
   parameter int unsigned N   = 3,
   parameter int unsigned LAT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_any,
   input  logic [N-1:0] win,
   output logic         busy,
   output logic         take,
   output logic         fire,
   output logic [N-1:0] gnt,
   output logic [N-1:0] done
);
   localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;

   lma_state_e    state;
   logic [CW-1:0] cnt;

   assign busy = (state == ST_BUSY);
   assign take = !busy && req_any;
   assign fire = busy && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         gnt   <= '0;
         cnt   <= '0;
         done  <= '0;
      end else begin
         done <= '0;
         if (take) begin
            state <= ST_BUSY;
            gnt   <= win;
            cnt   <= CW'(LAT - 1);
         end else if (fire) begin
            state <= ST_IDLE;
            done  <= gnt;
         end else if (busy) begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/lma_bank.sv
`timescale 1ns/1ps
// One word-wide storage bank with registered read.
module lma_bank #(
   parameter int unsigned W  = 32,
   parameter int unsigned AW = 6
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/line_mem_arbiter.sv
`timescale 1ns/1ps
module line_mem_arbiter
   import lma_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned WORDS   = 2,
   parameter int unsigned LINE_AW = 6,
   parameter int unsigned LAT     = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      d_req,
   input  logic [LINE_AW-1:0]        d_addr,
   output logic                      d_done,
   output logic [WORDS*WORD_W-1:0]   d_rdata,
   input  logic                      i_req,
   input  logic [LINE_AW-1:0]        i_addr,
   output logic                      i_done,
   output logic [WORDS*WORD_W-1:0]   i_rdata,
   input  logic                      w_req,
   input  logic [LINE_AW-1:0]        w_addr,
   input  logic [WORDS*WORD_W-1:0]   w_wdata,
   output logic                      w_done
);
   localparam int unsigned LINE_W = WORDS * WORD_W;

   if (LAT < 1)     begin : g_bad_lat   $error("LAT must be at least 1");     end
   if (WORDS < 1)   begin : g_bad_words $error("WORDS must be at least 1");   end
   if (WORD_W < 1)  begin : g_bad_width $error("WORD_W must be at least 1");  end
   if (LINE_AW < 1) begin : g_bad_aw    $error("LINE_AW must be at least 1"); end

   logic [NREQ-1:0]    req_v;
   logic [NREQ-1:0]    win;
   logic [NREQ-1:0]    gnt;
   logic [NREQ-1:0]    done_v;
   logic               busy;
   logic               take;
   logic               fire;
   logic [LINE_AW-1:0] a_q;
   logic [LINE_W-1:0]  wd_q;
   logic               we_q;
   logic [LINE_W-1:0]  rd_line;

   assign req_v[P_DATA]  = d_req;
   assign req_v[P_INSTR] = i_req;
   assign req_v[P_WB]    = w_req;

   lma_pick #(.N(NREQ)) u_pick (
      .req (req_v),
      .win (win)
   );

   lma_seq #(.N(NREQ), .LAT(LAT)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_any (|req_v),
      .win     (win),
      .busy    (busy),
      .take    (take),
      .fire    (fire),
      .gnt     (gnt),
      .done    (done_v)
   );

   // Address and write data are captured at the grant and held for the access.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q  <= '0;
         wd_q <= '0;
         we_q <= 1'b0;
      end else if (take) begin
         we_q <= win[P_WB];
         wd_q <= w_wdata;
         unique case (1'b1)
            win[P_DATA]:  a_q <= d_addr;
            win[P_INSTR]: a_q <= i_addr;
            default:      a_q <= w_addr;
         endcase
      end
   end

   // Word b of every line lives in bank b; all banks share the line address.
   for (genvar b = 0; b < WORDS; b++) begin : g_bank
      lma_bank #(.W(WORD_W), .AW(LINE_AW)) u_bank (
         .clk   (clk),
         .en    (fire),
         .we    (we_q),
         .addr  (a_q),
         .wdata (wd_q[b*WORD_W +: WORD_W]),
         .rdata (rd_line[b*WORD_W +: WORD_W])
      );
   end

   assign d_rdata = rd_line;
   assign i_rdata = rd_line;
   assign d_done  = done_v[P_DATA];
   assign i_done  = done_v[P_INSTR];
   assign w_done  = done_v[P_WB];
endmodule

// File: rtl/lma_checker.sv
`timescale 1ns/1ps
module lma_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       d_req,
   input logic       i_req,
   input logic       busy,
   input logic [2:0] gnt,
   input logic       d_done,
   input logic       i_done,
   input logic       w_done
);
   logic [2:0] done;
   assign done = {w_done, i_done, d_done};

   a_r2_data_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && d_req) |=> (busy && gnt == 3'b001));

   a_r2_instr_second: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !d_req && i_req) |=> (busy && gnt == 3'b010));

   a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(gnt));

   a_r4_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done));

   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |=> !(|done));

   a_r4_done_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |-> (done == $past(gnt)));

   a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> (done == 3'b000));
endmodule

bind line_mem_arbiter lma_checker u_lma_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .d_req  (d_req),
   .i_req  (i_req),
   .busy   (busy),
   .gnt    (gnt),
   .d_done (d_done),
   .i_done (i_done),
   .w_done (w_done)
);

// File: tb/line_mem_arbiter_bench.sv
`timescale 1ns/1ps
module line_mem_arbiter_bench;
   localparam int LAT = 4;
   localparam int AW  = 6;
   localparam int LW  = 64;
   localparam int P   = LAT + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          d_req = 1'b0, i_req = 1'b0, w_req = 1'b0;
   logic [AW-1:0] d_addr = '0, i_addr = '0, w_addr = '0;
   logic [LW-1:0] w_wdata = '0;
   logic          d_done, i_done, w_done;
   logic [LW-1:0] d_rdata, i_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   int done_at [3];
   logic [LW-1:0] got [3];

   always #2.5 clk = ~clk;

   line_mem_arbiter #(.WORD_W(32), .WORDS(2), .LINE_AW(AW), .LAT(LAT)) u_line_mem_arbiter (
      .clk(clk), .rst_n(rst_n),
      .d_req(d_req), .d_addr(d_addr), .d_done(d_done), .d_rdata(d_rdata),
      .i_req(i_req), .i_addr(i_addr), .i_done(i_done), .i_rdata(i_rdata),
      .w_req(w_req), .w_addr(w_addr), .w_wdata(w_wdata), .w_done(w_done)
   );

   task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Raise the requests in mask at a falling edge, drop each on its done.
   task automatic serve(input logic [2:0] mask);
      int t = 0;
      logic [2:0] pend = mask;
      for (int k = 0; k < 3; k++) done_at[k] = -1;
      d_req = mask[0]; i_req = mask[1]; w_req = mask[2];
      while (pend != 3'b000 && t < 200) begin
         @(negedge clk);
         t++;
         if (d_done) begin done_at[0] = t; got[0] = d_rdata; d_req = 1'b0; pend[0] = 1'b0; end
         if (i_done) begin done_at[1] = t; got[1] = i_rdata; i_req = 1'b0; pend[1] = 1'b0; end
         if (w_done) begin done_at[2] = t; w_req = 1'b0; pend[2] = 1'b0; end
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [LW-1:0] v);
      w_addr = a; w_wdata = v;
      serve(3'b100);
   endtask

   task automatic t_reset;
      chk(!d_done && !i_done && !w_done, "R1 done low after reset",
          {61'd0, w_done, i_done, d_done}, '0);
   endtask

   task automatic t_idle;
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (d_done || i_done || w_done) seen++;
      end
      chk(seen == 0, "R7 no done while idle", LW'(seen), '0);
   endtask

   task automatic t_single;
      do_write(6'd5, 64'h1111_2222_3333_4444);
      chk(done_at[2] == P, "R4 write latency", LW'(done_at[2]), LW'(P));
      chk(done_at[2] == P, "R1 first request accepted at once", LW'(done_at[2]), LW'(P));
      d_addr = 6'd5;
      serve(3'b001);
      chk(done_at[0] == P, "R4 read latency", LW'(done_at[0]), LW'(P));
      chk(got[0][31:0] == 32'h3333_4444, "R3 word0 lower half", LW'(got[0][31:0]), 64'h3333_4444);
      chk(got[0][63:32] == 32'h1111_2222, "R3 word1 upper half", LW'(got[0][63:32]), 64'h1111_2222);
      i_addr = 6'd5;
      serve(3'b010);
      chk(got[1] == 64'h1111_2222_3333_4444, "R8 instruction port reads same line", got[1], 64'h1111_2222_3333_4444);
   endtask

   task automatic t_priority;
      do_write(6'd6, 64'hAAAA_0000_BBBB_0001);
      d_addr = 6'd5; i_addr = 6'd6; w_addr = 6'd7; w_wdata = 64'hCAFE_F00D_DEAD_BEEF;
      serve(3'b111);
      chk(done_at[0] == P,     "R2 data served first",    LW'(done_at[0]), LW'(P));
      chk(done_at[1] == 2 * P, "R2 instruction second",   LW'(done_at[1]), LW'(2 * P));
      chk(done_at[2] == 3 * P, "R2 write-back last",      LW'(done_at[2]), LW'(3 * P));
      chk(got[0] == 64'h1111_2222_3333_4444, "R2 data line", got[0], 64'h1111_2222_3333_4444);
      chk(got[1] == 64'hAAAA_0000_BBBB_0001, "R2 instruction line", got[1], 64'hAAAA_0000_BBBB_0001);
      d_addr = 6'd7;
      serve(3'b001);
      chk(got[0] == 64'hCAFE_F00D_DEAD_BEEF, "R3 written line read back", got[0], 64'hCAFE_F00D_DEAD_BEEF);
      d_addr = 6'd5;
      serve(3'b001);
      chk(got[0] == 64'h1111_2222_3333_4444, "R9 other line untouched", got[0], 64'h1111_2222_3333_4444);
   endtask

   task automatic t_no_preempt;
      int t = 0;
      int i_t = -1, d_t = -1;
      i_addr = 6'd6; d_addr = 6'd7;
      i_req = 1'b1;
      while ((i_t < 0 || d_t < 0) && t < 100) begin
         @(negedge clk);
         t++;
         if (t == 1) d_req = 1'b1;
         if (i_done) begin i_t = t; i_req = 1'b0; end
         if (d_done) begin d_t = t; d_req = 1'b0; end
      end
      chk(i_t == P,     "R5 running access completes first", LW'(i_t), LW'(P));
      chk(d_t == 2 * P, "R5 late data request waits",        LW'(d_t), LW'(2 * P));
   endtask

   task automatic t_wb_wait;
      int t = 0, nd = 0, w_t = -1, early = 0, d2 = -1;
      d_addr = 6'd5; w_addr = 6'd9; w_wdata = 64'h0123_4567_89AB_CDEF;
      d_req = 1'b1; w_req = 1'b1;
      while (w_t < 0 && t < 200) begin
         @(negedge clk);
         t++;
         if (d_done) begin
            nd++;
            if (nd == 2) d2 = t;
            if (nd == 3) d_req = 1'b0;
         end
         if (w_done) begin
            w_t = t; w_req = 1'b0;
            if (nd < 3) early++;
         end
      end
      chk(early == 0,    "R6 write-back held behind reads", LW'(early), '0);
      chk(w_t == 4 * P,  "R6 write-back served after reads", LW'(w_t), LW'(4 * P));
      chk(d2 == 2 * P,   "R10 back-to-back spacing",         LW'(d2), LW'(2 * P));
      i_addr = 6'd9;
      serve(3'b010);
      chk(got[1] == 64'h0123_4567_89AB_CDEF, "R6 delayed write landed", got[1], 64'h0123_4567_89AB_CDEF);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_idle();
      t_single();
      t_priority();
      t_no_preempt();
      t_wb_wait();
      t_idle();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #500000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule